// File: doc/BRIEF.md
# Priority Queue Scanner with Current Priority Register

This block decides which interrupt a processor thread takes next. It keeps a bitmap of priorities that may have work, one bit for each of up to eight event queues, where priority 0 is the most favoured. On a scan request it tries the most favoured marked priority first and asks that queue, through a request/response port, for its head entry. A nonzero entry ends the scan and is reported. A zero entry means the queue is empty, so that priority's bit is dropped and the next marked priority is tried. When the bitmap runs out the scan reports nothing.

At the end of every scan the block updates its current processor priority register (CPPR). The register takes the winning priority, or 0xFF when nothing was found. The value 0xFF lets every priority through and 0x00 blocks delivery. A write strobe tells the delivery logic when the value really changed. A peek scan looks at the head entries without consuming them. It still drops the bits of empty queues and still updates the register.

Each queue also has an occupancy counter and a deferred-removal counter. Removals posted against a queue are not subtracted at once. They are folded into its occupancy only when a scan finds that queue empty, because only then can no entry still be sitting in it.

Top module: `prio_scan_cppr`

## Requirements
- R1: After reset, cppr is 0x00, pend_bits is 0, busy and done are low, and every occupancy count is 0.
- R2: When set_pend_valid is high, set_pend_mask is ORed into pend_bits. Bit i of pend_bits stands for priority i. Bits stay set until a scan finds their queue empty.
- R3: Each queue request names the lowest-numbered set bit of pend_bits on qreq_idx.
- R4: A nonzero qrsp_data ends the scan. done then pulses with found=1 and irq_id equal to that data, and the queue's pending bit stays set.
- R5: A zero qrsp_data clears that queue's pending bit and the scan moves on to the next lowest bit. A scan that empties the bitmap ends with found=0 and irq_id=0.
- R6: When done pulses, cppr holds the winning priority zero-extended to 8 bits, or 0xFF when found=0.
- R7: cppr_wr is high for exactly the done cycle, and only when that scan changed cppr. cppr never changes without it.
- R8: When a queue is found empty, its occupancy drops by its deferred count, with a floor of 0, and the deferred count returns to 0. A queue that returns an entry keeps its occupancy.
- R9: An accounting pulse with acct_op=0 raises the addressed queue's occupancy by 1, and one with acct_op=1 raises its deferred count by 1. Both saturate at 2^CNT_W-1.
- R10: scan_start while busy is ignored: each accepted start yields exactly one done pulse.
- R11: In a peek scan qreq_peek is high, so the queue returns its head entry without removing it. Empty-queue bit clearing and the CPPR update still happen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_start | input | 1 | Request a scan (taken only when idle) |
| scan_peek | input | 1 | The requested scan does not consume entries |
| set_pend_valid | input | 1 | OR set_pend_mask into the bitmap |
| set_pend_mask | input | NPRIO | Priorities to mark as possibly pending |
| acct_valid | input | 1 | Accounting pulse |
| acct_op | input | 1 | 0: add occupancy, 1: post a deferred removal |
| acct_idx | input | IW | Queue addressed by the accounting pulse |
| qreq_valid | output | 1 | Queue read request |
| qreq_idx | output | IW | Queue being read |
| qreq_peek | output | 1 | Read without removing the head entry |
| qrsp_valid | input | 1 | Queue response strobe |
| qrsp_data | input | EW | Head entry, 0 when the queue is empty |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle completion pulse |
| found | output | 1 | The completed scan returned an entry |
| irq_id | output | EW | Entry returned, 0 if none |
| cppr | output | 8 | Current processor priority |
| cppr_wr | output | 1 | Strobe: cppr took a new value this cycle |
| pend_bits | output | NPRIO | Pending-priority bitmap |
| occ_count | output | NPRIO*CNT_W | Occupancy counts, queue i at bits i*CNT_W upward |

## Verification
A wrong bitmap shows up on the next scan as a request to the wrong queue index, a cycle after the scan starts, or as a missed or extra empty-queue visit. A stale CPPR shows up at the next done pulse as a wrong value or a wrong presence of cppr_wr. Errors in the deferred count stay hidden until the queue is next found empty. The occupancy port shows them one cycle after the queue's zero response, and the bench compares all queues after each scan. A scan that accepts a second start gives a done pulse with no matching expected item.

// File: rtl/scan_pkg.sv
package scan_pkg;
  typedef enum logic [1:0] {S_IDLE, S_PICK, S_WAIT, S_DONE} scan_st_e;
  typedef enum logic {ACCT_ADD = 1'b0, ACCT_DEFER = 1'b1} acct_op_e;
  localparam logic [7:0] CPPR_OPEN  = 8'hFF;
  localparam logic [7:0] CPPR_CLOSE = 8'h00;
endpackage

// File: rtl/scan_lsb_pick.sv
module scan_lsb_pick #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  bits,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |bits;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (bits[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/scan_queue_acct.sv
module scan_queue_acct #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          add_en,
  input  logic          defer_en,
  input  logic          flush_en,
  output logic [CW-1:0] occ
);
  logic [CW-1:0] dcnt;
  logic [CW-1:0] occ_base;

  function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] v);
    return (&v) ? v : v + 1'b1;
  endfunction

  function automatic logic [CW-1:0] fold(input logic [CW-1:0] v, input logic [CW-1:0] s);
    return (v > s) ? v - s : '0;
  endfunction

  assign occ_base = flush_en ? fold(occ, dcnt) : occ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ  <= '0;
      dcnt <= '0;
    end else begin
      occ <= add_en ? sat_inc(occ_base) : occ_base;
      if (flush_en) dcnt <= defer_en ? CW'(1) : '0;
      else if (defer_en) dcnt <= sat_inc(dcnt);
    end
  end

  // R8: the deferred count is consumed when the queue is found empty
  a_r8_flush_resets_defer: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_en && !defer_en) |=> (dcnt == '0));
  // R8: a flush never raises occupancy
  a_r8_flush_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_en && !add_en) |=> (occ <= $past(occ)));
  // R9: an add grows occupancy by one below saturation
  a_r9_add_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (add_en && !flush_en && !(&occ)) |=> (occ == $past(occ) + 1'b1));
endmodule

// File: rtl/prio_scan_cppr.sv
module prio_scan_cppr
  import scan_pkg::*;
#(
  parameter int NPRIO = 8,
  parameter int EW    = 31,
  parameter int CNT_W = 6,
  parameter int IW    = (NPRIO > 1) ? $clog2(NPRIO) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   scan_start,
  input  logic                   scan_peek,
  input  logic                   set_pend_valid,
  input  logic [NPRIO-1:0]       set_pend_mask,
  input  logic                   acct_valid,
  input  logic                   acct_op,
  input  logic [IW-1:0]          acct_idx,
  output logic                   qreq_valid,
  output logic [IW-1:0]          qreq_idx,
  output logic                   qreq_peek,
  input  logic                   qrsp_valid,
  input  logic [EW-1:0]          qrsp_data,
  output logic                   busy,
  output logic                   done,
  output logic                   found,
  output logic [EW-1:0]          irq_id,
  output logic [7:0]             cppr,
  output logic                   cppr_wr,
  output logic [NPRIO-1:0]       pend_bits,
  output logic [NPRIO*CNT_W-1:0] occ_count
);
  scan_st_e      st;
  logic          peek_q;
  logic [IW-1:0] cur_idx;
  logic          res_found;
  logic [EW-1:0] res_irq;
  logic          pick_any;
  logic [IW-1:0] pick_idx;

  // named internal events
  logic             start_take, rsp_take, hit_seen, empty_seen;
  logic [NPRIO-1:0] clr_mask, set_mask;
  logic [7:0]       cppr_next;

  function automatic logic [7:0] cppr_of(input logic hit, input logic [IW-1:0] idx);
    return hit ? 8'(idx) : CPPR_OPEN;
  endfunction

  scan_lsb_pick #(.N(NPRIO), .IW(IW)) u_pick (
    .bits(pend_bits), .any(pick_any), .idx(pick_idx)
  );

  assign start_take = scan_start && (st == S_IDLE);
  assign rsp_take   = qrsp_valid && (st == S_WAIT);
  assign hit_seen   = rsp_take && (qrsp_data != '0);
  assign empty_seen = rsp_take && (qrsp_data == '0);
  assign clr_mask   = empty_seen ? (NPRIO'(1) << cur_idx) : '0;
  assign set_mask   = set_pend_valid ? set_pend_mask : '0;
  assign cppr_next  = cppr_of(res_found, cur_idx);

  assign busy       = (st != S_IDLE);
  assign qreq_valid = (st == S_PICK) && pick_any;
  assign qreq_idx   = pick_idx;
  assign qreq_peek  = peek_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      peek_q    <= 1'b0;
      cur_idx   <= '0;
      res_found <= 1'b0;
      res_irq   <= '0;
      pend_bits <= '0;
      done      <= 1'b0;
      found     <= 1'b0;
      irq_id    <= '0;
      cppr      <= CPPR_CLOSE;
      cppr_wr   <= 1'b0;
    end else begin
      pend_bits <= (pend_bits & ~clr_mask) | set_mask;
      done      <= 1'b0;
      cppr_wr   <= 1'b0;
      unique case (st)
        S_IDLE: if (start_take) begin
          peek_q <= scan_peek;
          st     <= S_PICK;
        end
        S_PICK: if (pick_any) begin
          cur_idx <= pick_idx;
          st      <= S_WAIT;
        end else begin
          res_found <= 1'b0;
          res_irq   <= '0;
          st        <= S_DONE;
        end
        S_WAIT: if (hit_seen) begin
          res_found <= 1'b1;
          res_irq   <= qrsp_data;
          st        <= S_DONE;
        end else if (empty_seen) begin
          st <= S_PICK;
        end
        S_DONE: begin
          done    <= 1'b1;
          found   <= res_found;
          irq_id  <= res_irq;
          cppr    <= cppr_next;
          cppr_wr <= (cppr_next != cppr);
          st      <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  for (genvar i = 0; i < NPRIO; i++) begin : g_acct
    scan_queue_acct #(.CW(CNT_W)) u_acct (
      .clk      (clk),
      .rst_n    (rst_n),
      .add_en   (acct_valid && (acct_op == ACCT_ADD) && (acct_idx == IW'(i))),
      .defer_en (acct_valid && (acct_op == ACCT_DEFER) && (acct_idx == IW'(i))),
      .flush_en (empty_seen && (cur_idx == IW'(i))),
      .occ      (occ_count[i*CNT_W +: CNT_W])
    );
  end

  // R3: the requested queue is marked and nothing more favoured is
  a_r3_req_marked: assert property (@(posedge clk) disable iff (!rst_n)
    qreq_valid |-> pend_bits[qreq_idx]);
  a_r3_req_lowest: assert property (@(posedge clk) disable iff (!rst_n)
    qreq_valid |-> ((pend_bits & ((NPRIO'(1) << qreq_idx) - 1'b1)) == '0));
  // R5: an empty response drops that priority's bit
  a_r5_empty_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_seen && !set_pend_valid) |=> !pend_bits[$past(cur_idx)]);
  // R4: a reported entry is never zero
  a_r4_found_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (done && found) |-> (irq_id != '0));
  // R6: a fruitless scan opens the priority register
  a_r6_none_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !found) |-> (cppr == CPPR_OPEN));
  // R7: strobe only with done, and the register moves only with the strobe
  a_r7_wr_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    cppr_wr |-> done);
  a_r7_wr_means_change: assert property (@(posedge clk) disable iff (!rst_n)
    cppr_wr |-> (cppr != $past(cppr)));
  a_r7_stable_without_wr: assert property (@(posedge clk) disable iff (!rst_n)
    !cppr_wr |-> $stable(cppr));
  // R10: completions never come back to back
  a_r10_single_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/sim_prio_scan_cppr.sv
`timescale 1ns/1ps
module sim_prio_scan_cppr;
  localparam int N = 8, EW = 31, CW = 6, IW = 3, DEP = 4;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scan_start = 0, scan_peek = 0, set_pend_valid = 0, acct_valid = 0, acct_op = 0;
  logic [N-1:0] set_pend_mask = '0;
  logic [IW-1:0] acct_idx = '0;
  logic qrsp_valid = 0;
  logic [EW-1:0] qrsp_data = '0;
  logic qreq_valid, qreq_peek, busy, done, found, cppr_wr;
  logic [IW-1:0] qreq_idx;
  logic [EW-1:0] irq_id;
  logic [7:0] cppr;
  logic [N-1:0] pend_bits;
  logic [N*CW-1:0] occ_count;

  always #10 clk = ~clk;

  prio_scan_cppr #(.NPRIO(N), .EW(EW), .CNT_W(CW)) u0 (
    .clk, .rst_n, .scan_start, .scan_peek, .set_pend_valid, .set_pend_mask,
    .acct_valid, .acct_op, .acct_idx, .qreq_valid, .qreq_idx, .qreq_peek,
    .qrsp_valid, .qrsp_data, .busy, .done, .found, .irq_id, .cppr, .cppr_wr,
    .pend_bits, .occ_count);

  int errors = 0, checks = 0, dones = 0, exp_dones = 0;
  bit finished = 0;

  // queue storage shared by the model and the responder
  int qmem [N][DEP];
  int rhead [N];
  // independent model state
  int mhead [N];
  int mocc [N];
  int mdef [N];
  int mcppr = 0;
  logic [N-1:0] mpend = '0;

  int exp_req[$];            // idx*2 + peek
  logic [40:0] exp_res[$];   // {wr, cppr[7:0], found, irq[30:0]}

  task automatic chk(input bit ok, input string r, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", r, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // queue responder: answers one cycle after a request
  bit rsp_due = 0;
  int rsp_val = 0;
  always @(negedge clk) begin
    qrsp_valid = 1'b0;
    qrsp_data  = '0;
    if (rsp_due) begin
      qrsp_valid = 1'b1;
      qrsp_data  = EW'(rsp_val);
      rsp_due = 0;
    end
    if (rst_n && qreq_valid) begin
      int e;
      int ri;
      e = (exp_req.size() > 0) ? exp_req.pop_front() : -1;
      chk(e == int'(qreq_idx) * 2 + int'(qreq_peek), "R3/R11 request idx*2+peek", int'(qreq_idx) * 2 + int'(qreq_peek), e);
      ri = int'(qreq_idx);
      rsp_val = (rhead[ri] < DEP) ? qmem[ri][rhead[ri]] : 0;
      if (!qreq_peek && rsp_val != 0) rhead[ri]++;
      rsp_due = 1;
    end
  end

  // monitor: compares completions against the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (cppr_wr && !done) chk(0, "R7 strobe outside done", 1, 0);
      if (done) begin
        dones++;
        if (exp_res.size() == 0) chk(0, "R10 unexpected done", 1, 0);
        else begin
          logic [40:0] x;
          x = exp_res.pop_front();
          chk(found == x[31], "R4/R5 found", found, x[31]);
          chk(irq_id == x[30:0], "R4 irq_id", irq_id, x[30:0]);
          chk(cppr == x[39:32], "R6 cppr", cppr, x[39:32]);
          chk(cppr_wr == x[40], "R7 cppr_wr", cppr_wr, x[40]);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    summary();
  end

  function automatic int lowest(input logic [N-1:0] b);
    for (int i = 0; i < N; i++) if (b[i]) return i;
    return -1;
  endfunction

  task automatic scan(input bit peek, input bit extra_start);
    bit hit = 0;
    int irq = 0, pr = 0, newc;
    while (mpend != 0 && !hit) begin
      int p;
      int v;
      p = lowest(mpend);
      exp_req.push_back(p * 2 + int'(peek));
      v = (mhead[p] < DEP) ? qmem[p][mhead[p]] : 0;
      if (v != 0) begin
        hit = 1; irq = v; pr = p;
        if (!peek) mhead[p]++;
      end else begin
        mpend[p] = 1'b0;
        mocc[p] = (mocc[p] > mdef[p]) ? mocc[p] - mdef[p] : 0;
        mdef[p] = 0;
      end
    end
    newc = hit ? pr : 255;
    exp_res.push_back({(newc != mcppr), 8'(newc), hit, 31'(irq)});
    mcppr = newc;
    exp_dones++;
    @(negedge clk);
    scan_start = 1; scan_peek = peek;
    @(negedge clk);
    scan_start = extra_start;
    @(negedge clk);
    scan_start = 0; scan_peek = 0;
    for (int k = 0; k < 60 && exp_res.size() != 0; k++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic set_pend(input logic [N-1:0] m);
    @(negedge clk);
    set_pend_valid = 1; set_pend_mask = m;
    @(negedge clk);
    set_pend_valid = 0; set_pend_mask = '0;
    mpend |= m;
  endtask

  task automatic acct(input int idx, input bit op, input int times);
    for (int k = 0; k < times; k++) begin
      @(negedge clk);
      acct_valid = 1; acct_op = op; acct_idx = IW'(idx);
      if (!op) mocc[idx] = (mocc[idx] < CMAX) ? mocc[idx] + 1 : CMAX;
      else     mdef[idx] = (mdef[idx] < CMAX) ? mdef[idx] + 1 : CMAX;
    end
    @(negedge clk);
    acct_valid = 0;
  endtask

  task automatic check_occ(input string r);
    for (int i = 0; i < N; i++)
      chk(int'(occ_count[i*CW +: CW]) == mocc[i], r, occ_count[i*CW +: CW], mocc[i]);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      rhead[i] = 0; mhead[i] = 0; mocc[i] = 0; mdef[i] = 0;
      for (int j = 0; j < DEP; j++) qmem[i][j] = 0;
    end
    qmem[2][0] = 'h111; qmem[2][1] = 'h222; qmem[5][0] = 'h555;
    qmem[1][0] = 'h77;  qmem[1][1] = 'h88;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(cppr == 8'h00, "R1 cppr", cppr, 0);
    chk(pend_bits == '0, "R1 pend_bits", pend_bits, 0);
    chk(!busy && !done, "R1 busy/done", {busy, done}, 0);
    check_occ("R1 occupancy");
    // R5/R6/R7: empty bitmap, register opens with a strobe, then no strobe
    scan(0, 0);
    scan(0, 0);
    // R2 bitmap set
    set_pend(8'b0010_0101);
    chk(pend_bits == 8'h25, "R2 pend_bits", pend_bits, 'h25);
    // R5 queue 0 empty, R4 queue 2 hit
    scan(0, 0);
    chk(pend_bits == 8'h24, "R4/R5 pend_bits after hit", pend_bits, 'h24);
    // R11 peek twice sees the same entry
    scan(1, 0);
    scan(1, 0);
    scan(0, 0);
    scan(0, 0);
    chk(pend_bits == 8'h20, "R5 pend_bits", pend_bits, 'h20);
    // R9 accounting, R8 flush on empty queue 5
    acct(5, 0, 3); acct(5, 1, 2); acct(1, 0, 2);
    check_occ("R9 occupancy adds");
    scan(0, 0);
    check_occ("R8 flush of queue 5");
    // R8 no flush when the queue returns an entry
    acct(1, 1, 1);
    set_pend(8'b0000_0010);
    scan(0, 0);
    check_occ("R8 no flush on hit");
    // R10 start while busy is ignored
    scan(0, 1);
    repeat (6) @(negedge clk);
    chk(dones == exp_dones, "R10 done count", dones, exp_dones);
    // R11 peek still clears empty bits and flushes
    set_pend(8'b0000_1000);
    scan(1, 0);
    chk(pend_bits == '0, "R11 peek clears empty bits", pend_bits, 0);
    check_occ("R11/R8 occupancy after peek scan");
    // R9 saturation, R8 full flush and floor at zero
    acct(0, 0, 70);
    chk(int'(occ_count[0 +: CW]) == CMAX, "R9 saturation", occ_count[0 +: CW], CMAX);
    acct(0, 1, 70);
    acct(4, 1, 5); acct(4, 0, 2);
    set_pend(8'b0001_0001);
    scan(0, 0);
    check_occ("R8 floor and full flush");
    chk(exp_req.size() == 0, "R3 all requests seen", exp_req.size(), 0);
    summary();
  end
endmodule